// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is the control path that lets an external or internal event steer a general-purpose up-counter. A select field chooses the trigger source from four internal trigger lines, two timer input pins and an external clock pin. Each pin has its own polarity bit, and every source is resynchronised to the counter clock by two flops. The rising edge and level of the selected source are then used according to a slave-mode field. In trigger mode the edge starts the counter. In gated mode the level lets it count. In reset mode the edge zeroes it. In external-clock-1 mode each edge is one count.

The counter can also take its count tick from the external clock pin (external clock mode 2) while a slave mode uses a different trigger source. Combinations that cannot work together are refused: the counter is stopped and a sticky error bit is raised. Software sees the count, a counter-enable bit it can write, and a trigger flag that stays set until software clears it.

Top module: `tim_slave_ctl`

## Requirements
- R1: After reset `cnt` is 0 and `cen`, `tif` and `cfg_err` are 0.
- R2: With `smode` = 000, software sets or clears `cen` through `cen_wr`/`cen_wdata`. While `cen` is 1, `cnt` rises by one on every clock edge. While `cen` is 0, `cnt` holds.
- R3: With `smode` = 110 (trigger mode), an active edge on the selected source sets `cen` on the third rising clock edge after the pin changes. The first increment of `cnt` happens on the fourth edge.
- R4: Every accepted trigger edge in slave modes 100 to 111 sets `tif` on the same edge that it would set `cen`. `tif` stays 1 until a cycle with `tif_clr` = 1. If a trigger arrives in the same cycle as a clear, the trigger wins.
- R5: In trigger mode, a further trigger while `cen` is 1 sets `tif` again. It does not reset or restart the count.
- R6: With `smode` = 101 (gated), `cnt` advances only while the synchronised source is at its active level. It holds while the source is inactive and resumes from the held value. The gate reaches the counter two clock edges after the pin changes.
- R7: With `smode` = 100 (reset mode), an active edge clears `cnt` to 0 on the third clock edge after the pin change. Counting continues from 0 afterwards.
- R8: The polarity bits `pol_ti1`, `pol_ti2` and `pol_etr` are 0 for rising edge / high level and 1 for falling edge / low level. Internal trigger lines are always rising / high.
- R9: `tsel` codes select the source: 0 to 3 select `itr[0]` to `itr[3]`, 4 selects nothing, 5 selects `ti1`, 6 selects `ti2` and 7 selects `etr`. Unselected sources have no effect on `tif` or `cen`.
- R10: With `ext2_en` = 1 and a legal slave mode, `cnt` advances once per active edge of `etr` (polarity `pol_etr`) instead of once per clock. The trigger source still acts as its slave mode defines.
- R11: `ext2_en` = 1 together with `smode` 001, 010, 011 or 111, or with `tsel` = 7, is illegal. On the next edge `cen` is forced to 0 and `cfg_err` is set. While the illegal setting lasts, `cnt` holds and `tif` is not set. `cfg_err` stays 1 until reset.
- R12: With `smode` = 111 and `ext2_en` = 0, `cnt` advances once per active edge of the selected source while `cen` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smode | input | 3 | Slave mode: 000 off, 001-011 encoder (not counted here), 100 reset, 101 gated, 110 trigger, 111 ext clock 1 |
| tsel | input | 3 | Trigger source select |
| ext2_en | input | 1 | Count on `etr` edges (external clock mode 2) |
| pol_ti1 | input | 1 | Polarity of `ti1` (1 = falling/low) |
| pol_ti2 | input | 1 | Polarity of `ti2` (1 = falling/low) |
| pol_etr | input | 1 | Polarity of `etr` (1 = falling/low) |
| itr | input | 4 | Internal trigger lines |
| ti1 | input | 1 | Timer input pin 1 |
| ti2 | input | 1 | Timer input pin 2 |
| etr | input | 1 | External clock / trigger pin |
| cen_wr | input | 1 | Software write strobe for the enable bit |
| cen_wdata | input | 1 | Value written to the enable bit |
| tif_clr | input | 1 | Software clear of the trigger flag |
| cnt | output | CNT_W | Counter value |
| cen | output | 1 | Counter enable |
| tif | output | 1 | Trigger flag |
| cfg_err | output | 1 | Sticky illegal-configuration status |

## Verification
A table of vectors toggles one source at a time against each `tsel` code, with both polarity settings. It shows whether the selector routes the right pin and ignores the others, and whether a falling edge is honoured only when its polarity bit asks for it. Directed runs then use a single clean edge in trigger mode to pin down the exact three-edge latency. A square wave on the gate in gated mode separates holding from resetting. Edges in reset and external-clock modes show that each edge clears the count or adds one to it, never more. Illegal mode pairs are checked to stop the counter and leave a sticky error bit.

// File: rtl/tim_slave_ctl.sv
module tim_slave_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       smode,
  input  logic [2:0]       tsel,
  input  logic             ext2_en,
  input  logic             pol_ti1,
  input  logic             pol_ti2,
  input  logic             pol_etr,
  input  logic [3:0]       itr,
  input  logic             ti1,
  input  logic             ti2,
  input  logic             etr,
  input  logic             cen_wr,
  input  logic             cen_wdata,
  input  logic             tif_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             cen,
  output logic             tif,
  output logic             cfg_err
);
  localparam logic [2:0] M_RESET = 3'b100;
  localparam logic [2:0] M_GATED = 3'b101;
  localparam logic [2:0] M_TRIG  = 3'b110;
  localparam logic [2:0] M_EXT1  = 3'b111;

  logic [6:0] sync1, sync2;
  logic       lvl, lvl_q, etr_lvl, etr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {etr, ti2, ti1, itr};
      sync2 <= sync1;
    end

  always_comb begin
    case (tsel)
      3'd0, 3'd1, 3'd2, 3'd3: lvl = sync2[{1'b0, tsel[1:0]}];
      3'd5:                   lvl = sync2[4] ^ pol_ti1;
      3'd6:                   lvl = sync2[5] ^ pol_ti2;
      3'd7:                   lvl = sync2[6] ^ pol_etr;
      default:                lvl = 1'b0;
    endcase
  end

  assign etr_lvl = sync2[6] ^ pol_etr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q <= 1'b0;
      etr_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      etr_q <= etr_lvl;
    end

  wire trg_edge = lvl & ~lvl_q;
  wire etr_edge = etr_lvl & ~etr_q;
  wire enc_mode = (smode != 3'b000) && !smode[2];
  wire bad      = ext2_en & (enc_mode | (smode == M_EXT1) | (tsel == 3'd7));
  wire trg_evt  = smode[2] & trg_edge & ~bad;
  wire tick     = ext2_en ? etr_edge : ((smode == M_EXT1) ? trg_edge : 1'b1);
  wire gate_ok  = (smode != M_GATED) | lvl;
  wire run      = cen & tick & gate_ok & ~bad & ~enc_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt <= '0;
    else if (trg_evt && smode == M_RESET) cnt <= '0;
    else if (run)                        cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cen <= 1'b0;
    else if (bad)                        cen <= 1'b0;
    else if (trg_evt && smode == M_TRIG) cen <= 1'b1;
    else if (cen_wr)                     cen <= cen_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        tif <= 1'b0;
    else if (trg_evt)  tif <= 1'b1;
    else if (tif_clr)  tif <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cfg_err <= 1'b0;
    else if (bad) cfg_err <= 1'b1;
endmodule

// File: rtl/tim_slave_ctl_chk.sv
module tim_slave_ctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       smode,
  input logic [2:0]       tsel,
  input logic             ext2_en,
  input logic             cen_wr,
  input logic             cen_wdata,
  input logic             tif_clr,
  input logic [CNT_W-1:0] cnt,
  input logic             cen,
  input logic             tif,
  input logic             cfg_err
);
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && smode != 3'b100) |=> $stable(cnt));

  assert_step_or_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(cnt) || cnt == '0 || cnt == $past(cnt) + 1'b1));

  assert_start_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !(cen_wr && cen_wdata) && smode != 3'b110) |=> !cen);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tif && !tif_clr) |=> tif);

  assert_refuse_combo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext2_en && (smode == 3'b111 || tsel == 3'd7)) |=> (cfg_err && !cen));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind tim_slave_ctl tim_slave_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smode(smode), .tsel(tsel), .ext2_en(ext2_en),
  .cen_wr(cen_wr), .cen_wdata(cen_wdata), .tif_clr(tif_clr),
  .cnt(cnt), .cen(cen), .tif(tif), .cfg_err(cfg_err)
);

// File: tb/test_tim_slave_ctl.sv
module test_tim_slave_ctl;
  localparam int CNT_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] smode = '0, tsel = '0;
  logic ext2_en = 0, pol_ti1 = 0, pol_ti2 = 0, pol_etr = 0;
  logic [3:0] itr = '0;
  logic ti1 = 0, ti2 = 0, etr = 0, cen_wr = 0, cen_wdata = 0, tif_clr = 0;
  logic [CNT_W-1:0] cnt;
  logic cen, tif, cfg_err;
  int n_chk = 0, n_bad = 0;
  logic [CNT_W-1:0] base;

  always #5 clk = ~clk;

  tim_slave_ctl #(.CNT_W(CNT_W)) i_tim_slave_ctl (
    .clk(clk), .rst_n(rst_n), .smode(smode), .tsel(tsel), .ext2_en(ext2_en),
    .pol_ti1(pol_ti1), .pol_ti2(pol_ti2), .pol_etr(pol_etr), .itr(itr),
    .ti1(ti1), .ti2(ti2), .etr(etr), .cen_wr(cen_wr), .cen_wdata(cen_wdata),
    .tif_clr(tif_clr), .cnt(cnt), .cen(cen), .tif(tif), .cfg_err(cfg_err));

  // {tsel, pol ti1/ti2/etr, toggled source, expected trigger}
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {3'd6, 3'b000, 3'd6, 1'b1}, {3'd6, 3'b010, 3'd6, 1'b1},
    {3'd6, 3'b000, 3'd5, 1'b0}, {3'd5, 3'b000, 3'd5, 1'b1},
    {3'd5, 3'b100, 3'd5, 1'b1}, {3'd7, 3'b000, 3'd7, 1'b1},
    {3'd7, 3'b001, 3'd7, 1'b1}, {3'd0, 3'b000, 3'd0, 1'b1},
    {3'd3, 3'b000, 3'd3, 1'b1}, {3'd2, 3'b000, 3'd1, 1'b0},
    {3'd4, 3'b000, 3'd5, 1'b0}, {3'd5, 3'b000, 3'd6, 1'b0}};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cen(input logic v);
    cen_wr = 1; cen_wdata = v; step(1); cen_wr = 0;
  endtask

  task automatic clr_tif();
    tif_clr = 1; step(1); tif_clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(2); rst_n = 1; step(1);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step(1);
    chk("R1 cnt", cnt, 0); chk("R1 cen", cen, 0);
    chk("R1 tif", tif, 0); chk("R1 cfg_err", cfg_err, 0);

    smode = 3'b110;
    for (int v = 0; v < NV; v++) begin
      tsel = VEC[v][9:7];
      {pol_ti1, pol_ti2, pol_etr} = VEC[v][6:4];
      ti1 = pol_ti1; ti2 = pol_ti2; etr = pol_etr; itr = '0;
      cen_wr = 1; cen_wdata = 0; step(4);
      tif_clr = 1; step(1); tif_clr = 0; cen_wr = 0;
      case (VEC[v][3:1])
        3'd5: ti1 = ~ti1;
        3'd6: ti2 = ~ti2;
        3'd7: etr = ~etr;
        default: itr[VEC[v][2:1]] = 1'b1;
      endcase
      step(4);
      chk("R9/R8 tif", tif, VEC[v][0]);
      chk("R9/R8 cen", cen, VEC[v][0]);
    end

    // R3 latency and R4 flag
    smode = 3'b110; tsel = 3'd6; pol_ti1 = 0; pol_ti2 = 0; pol_etr = 0;
    ti1 = 0; ti2 = 0; etr = 0; itr = '0;
    cen_wr = 1; cen_wdata = 0; step(4);
    tif_clr = 1; step(1); tif_clr = 0; cen_wr = 0;
    base = cnt;
    ti2 = 1; step(2);
    chk("R3 cen after 2 edges", cen, 0);
    step(1);
    chk("R3 cen after 3 edges", cen, 1);
    chk("R4 tif with cen", tif, 1);
    chk("R3 no count yet", cnt, base);
    step(1);
    chk("R3 first count", cnt, base + 1);
    step(6);
    chk("R4 tif sticky", tif, 1);
    // R5 second trigger does not restart
    ti2 = 0; step(3);
    clr_tif();
    chk("R4 tif cleared", tif, 0);
    ti2 = 1; step(4);
    chk("R5 tif again", tif, 1);
    chk("R5 no restart", cnt, base + 1 + 6 + 8);

    // R2 software enable
    smode = 3'b000; wr_cen(1);
    base = cnt; step(7);
    chk("R2 free count", cnt, base + 7);
    wr_cen(0);
    base = cnt; step(5);
    chk("R2 hold", cnt, base);

    // R6 gated
    smode = 3'b101; ti2 = 0; wr_cen(1); step(4);
    base = cnt; step(3);
    chk("R6 hold inactive", cnt, base);
    ti2 = 1; step(10);
    chk("R6 count active", cnt, base + 8);
    ti2 = 0; step(10);
    chk("R6 hold after fall", cnt, base + 10);
    ti2 = 1; step(10);
    chk("R6 resume", cnt, base + 18);

    // R7 reset mode
    smode = 3'b100; ti2 = 0; step(4);
    ti2 = 1; step(3);
    chk("R7 cleared", cnt, 0);
    step(2);
    chk("R7 counts on", cnt, 2);

    // R12 external clock 1
    smode = 3'b111; ti2 = 0; step(4);
    base = cnt; step(4);
    chk("R12 no edges", cnt, base);
    for (int p = 0; p < 3; p++) begin
      ti2 = 1; step(4); ti2 = 0; step(4);
    end
    chk("R12 three edges", cnt, base + 3);

    // R10 external clock 2
    smode = 3'b000; ext2_en = 1; etr = 0; step(4);
    base = cnt; step(5);
    chk("R10 idle etr", cnt, base);
    for (int p = 0; p < 4; p++) begin
      etr = 1; step(4); etr = 0; step(4);
    end
    chk("R10 four etr edges", cnt, base + 4);
    smode = 3'b110; wr_cen(0); step(4);
    ti2 = 1; step(4);
    chk("R10 trigger with ext2", cen, 1);

    // R11 illegal combination
    smode = 3'b000; ti2 = 0; wr_cen(1); clr_tif(); step(2);
    smode = 3'b111; step(1);
    chk("R11 cfg_err", cfg_err, 1);
    chk("R11 cen forced", cen, 0);
    base = cnt;
    ti2 = 1; etr = 1; step(4); etr = 0; step(4);
    chk("R11 cnt held", cnt, base);
    chk("R11 no tif", tif, 0);
    smode = 3'b000; ext2_en = 0; step(3);
    chk("R11 sticky", cfg_err, 1);
    do_reset();
    chk("R1 err cleared", cfg_err, 0);
    ext2_en = 1; smode = 3'b110; tsel = 3'd7; step(1);
    chk("R11 etr as trigger", cfg_err, 1);
    ext2_en = 0; tsel = 3'd6; smode = 3'b000;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule